// File: doc/BRIEF.md
# GPIO Port Interrupt Controller

This block watches the input pins of one GPIO port and turns pin activity into interrupt requests. Each pin is first passed through a two-flop synchronizer. A per-pin detector then recognises either a held logic level or a transition. A transition can be a rising edge, a falling edge, or either one. A small register bus sets the detection mode, the polarity, the masking and the ADC trigger enables for each pin. The same bus reports raw and masked status and clears latched transitions.

Three outputs leave the block. The first is one interrupt line for the whole port. The second is a set of per-pin interrupt lines, in which line 0 also carries the summary of all pins. The third is a single-cycle pulse that starts an ADC conversion when a masked, ADC-enabled pin raises a new interrupt. Software is expected to mask a pin before it changes that pin's mode, polarity or both-edge setting. Any of those writes can create a spurious condition.

The register bus is a plain control port. A write takes effect on the clock edge where `bus_sel` and `bus_wr` are both high. Read data is combinational from `bus_addr` whenever `bus_sel` is high and `bus_wr` is low.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0, and `port_irq`, `pin_irq` and `adc_trig` are low.
- R2: The register map is: address 0 mode (1 = level, 0 = edge), 1 both-edge select, 2 polarity, 3 mask, 4 raw status (read-only), 5 masked status (read-only), 6 clear (write-only, reads 0), 7 ADC enable. Writes to addresses 4 and 5 have no effect.
- R3: An edge-mode pin with both-edge clear sets its raw bit on a rising edge when its polarity bit is 1, and on a falling edge when its polarity bit is 0. A transition of the other direction does nothing. The raw bit changes on the third clock edge after the pin changes.
- R4: An edge-mode pin whose both-edge bit is 1 sets its raw bit on rising and on falling transitions, whatever its polarity bit holds.
- R5: An edge-mode raw bit stays set until a 1 is written to the same bit of the clear register. Writing a 0 there leaves it set.
- R6: A level-mode raw bit is 1 exactly while the synchronized input equals the active level (polarity 1 = high, 0 = low). Writes to the clear register do not change it.
- R7: Masked status equals raw status ANDed with the mask register.
- R8: `port_irq` is high when any masked status bit is set.
- R9: `pin_irq[i]` equals masked status bit i for i ≥ 1, and `pin_irq[0]` is the OR of all masked status bits.
- R10: `adc_trig` pulses high for exactly one cycle when a masked status bit whose ADC-enable bit is set goes from 0 to 1. A pin with its mask bit clear never produces a pulse.
- R11: When a new edge and a clear write hit the same edge-mode pin in the same cycle, the raw bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pins | input | NPINS | Asynchronous pin inputs |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Read data |
| port_irq | output | 1 | Aggregated port interrupt |
| pin_irq | output | NPINS | Per-pin interrupt lines, bit 0 is the summary |
| adc_trig | output | 1 | One-cycle ADC start pulse |

## Verification
The bench builds the block with the default of eight pins and two synchronizer stages. With that setting the register data width is one byte, and distinct pins can exercise each detection mode side by side: rising, falling, both-edge, level-high and level-low. The fixed three-edge latency from pin to status lets the bench place a clear write exactly on the cycle where an edge is detected. It also lets the bench count ADC pulses within a bounded window.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_MODE   = 3'd0,
    REG_BOTH   = 3'd1,
    REG_POL    = 3'd2,
    REG_MASK   = 3'd3,
    REG_RAW    = 3'd4,
    REG_MASKED = 3'd5,
    REG_CLEAR  = 3'd6,
    REG_ADC    = 3'd7
  } reg_addr_e;

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d_async;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q_sync = stg[STAGES-1];

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_s,
  input  logic [NPINS-1:0] mode_lvl,
  input  logic [NPINS-1:0] both,
  input  logic [NPINS-1:0] pol,
  input  logic [NPINS-1:0] clr,
  output logic [NPINS-1:0] raw,
  output logic [NPINS-1:0] edge_hit
);

  logic [NPINS-1:0] prev;

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= '0;
    else        prev <= pin_s;
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic rise, fall, lvl_act, raw_b;

    assign rise        = pin_s[i] & ~prev[i];
    assign fall        = ~pin_s[i] & prev[i];
    assign edge_hit[i] = both[i] ? (rise | fall) : (pol[i] ? rise : fall);
    assign lvl_act     = pol[i] ? pin_s[i] : ~pin_s[i];

    // Level pins track the input; edge pins latch, and a fresh edge outranks a clear.
    always_ff @(posedge clk) begin
      if (!rst_n)          raw_b <= 1'b0;
      else if (mode_lvl[i]) raw_b <= lvl_act;
      else                 raw_b <= edge_hit[i] | (raw_b & ~clr[i]);
    end

    assign raw[i] = raw_b;
  end

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  raw,
  output logic [NPINS-1:0]  mode_lvl,
  output logic [NPINS-1:0]  both,
  output logic [NPINS-1:0]  pol,
  output logic [NPINS-1:0]  mask,
  output logic [NPINS-1:0]  adc_en,
  output logic [NPINS-1:0]  clr,
  output logic [NPINS-1:0]  mis
);

  reg_addr_e sel_reg;
  logic      wr_en;

  assign sel_reg = reg_addr_e'(bus_addr);
  assign wr_en   = bus_sel & bus_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_lvl <= '0;
      both     <= '0;
      pol      <= '0;
      mask     <= '0;
      adc_en   <= '0;
    end else if (wr_en) begin
      case (sel_reg)
        REG_MODE: mode_lvl <= bus_wdata;
        REG_BOTH: both     <= bus_wdata;
        REG_POL:  pol      <= bus_wdata;
        REG_MASK: mask     <= bus_wdata;
        REG_ADC:  adc_en   <= bus_wdata;
        default:  ;
      endcase
    end
  end

  assign clr = (wr_en && sel_reg == REG_CLEAR) ? bus_wdata : '0;
  assign mis = raw & mask;

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (sel_reg)
        REG_MODE:   bus_rdata = mode_lvl;
        REG_BOTH:   bus_rdata = both;
        REG_POL:    bus_rdata = pol;
        REG_MASK:   bus_rdata = mask;
        REG_RAW:    bus_rdata = raw;
        REG_MASKED: bus_rdata = mis;
        REG_ADC:    bus_rdata = adc_en;
        default:    bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_irq_out.sv
module gpio_irq_out #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] mis,
  input  logic [NPINS-1:0] adc_en,
  output logic             port_irq,
  output logic [NPINS-1:0] pin_irq,
  output logic             adc_trig
);

  logic [NPINS-1:0] mis_prev;
  logic             any_mis;

  always_ff @(posedge clk) begin
    if (!rst_n) mis_prev <= '0;
    else        mis_prev <= mis;
  end

  assign any_mis  = |mis;
  assign port_irq = any_mis;
  assign pin_irq  = {mis[NPINS-1:1], any_mis};
  assign adc_trig = |(mis & ~mis_prev & adc_en);

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NPINS       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pins,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  output logic              port_irq,
  output logic [NPINS-1:0]  pin_irq,
  output logic              adc_trig
);

  logic [NPINS-1:0] pin_s, cfg_mode, cfg_both, cfg_pol, cfg_mask, cfg_adc;
  logic [NPINS-1:0] clr_vec, raw_st, edge_hit, mis_st;

  gpio_irq_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(pins), .q_sync(pin_s)
  );

  gpio_irq_detect #(.NPINS(NPINS)) u_det (
    .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .mode_lvl(cfg_mode),
    .both(cfg_both), .pol(cfg_pol), .clr(clr_vec), .raw(raw_st),
    .edge_hit(edge_hit)
  );

  gpio_irq_regs #(.NPINS(NPINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .raw(raw_st), .mode_lvl(cfg_mode), .both(cfg_both), .pol(cfg_pol),
    .mask(cfg_mask), .adc_en(cfg_adc), .clr(clr_vec), .mis(mis_st)
  );

  gpio_irq_out #(.NPINS(NPINS)) u_out (
    .clk(clk), .rst_n(rst_n), .mis(mis_st), .adc_en(cfg_adc),
    .port_irq(port_irq), .pin_irq(pin_irq), .adc_trig(adc_trig)
  );

endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NPINS-1:0]  bus_wdata,
  input logic              port_irq,
  input logic [NPINS-1:0]  pin_irq,
  input logic              adc_trig,
  input logic [NPINS-1:0]  mode_lvl,
  input logic [NPINS-1:0]  mask,
  input logic [NPINS-1:0]  adc_en,
  input logic [NPINS-1:0]  raw,
  input logic [NPINS-1:0]  hit
);

  logic mode_wr;
  assign mode_wr = bus_sel && bus_wr && (bus_addr == REG_MODE);

  assert_trig_implies_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    adc_trig |-> port_irq);

  assert_trig_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    adc_trig |-> (adc_en != '0));

  assert_irq_has_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    port_irq |-> (raw != '0));

  assert_lines_respect_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_irq[NPINS-1:1] & ~mask[NPINS-1:1]) == '0);

  for (genvar i = 0; i < NPINS; i++) begin : g_bit
    logic clr_bit;
    assign clr_bit = bus_sel && bus_wr && (bus_addr == REG_CLEAR) && bus_wdata[i];

    assert_edge_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_lvl[i] && raw[i] && !clr_bit && !mode_wr) |=> raw[i]);

    assert_edge_beats_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_lvl[i] && hit[i] && !mode_wr) |=> raw[i]);
  end

endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .port_irq(port_irq),
  .pin_irq(pin_irq), .adc_trig(adc_trig), .mode_lvl(cfg_mode),
  .mask(cfg_mask), .adc_en(cfg_adc), .raw(raw_st), .hit(edge_hit)
);

// File: tb/tb_gpio_irq_ctrl.sv
module tb_gpio_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pins = '0;
  logic          bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0]    bus_addr = '0;
  logic [NP-1:0] bus_wdata = '0;
  logic [NP-1:0] bus_rdata;
  logic          port_irq, adc_trig;
  logic [NP-1:0] pin_irq;

  int checks = 0, fails = 0, adc_cnt = 0, c0 = 0;
  logic [NP-1:0] exp_q[$];
  string         tag_q[$];
  bit            done = 0;

  gpio_irq_ctrl #(.NPINS(NP)) dut (
    .clk(clk), .rst_n(rst_n), .pins(pins), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .port_irq(port_irq), .pin_irq(pin_irq), .adc_trig(adc_trig)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (rst_n && adc_trig) adc_cnt++;

  // Scoreboard monitor: compares each read beat with the expected item queued by the driver.
  always @(negedge clk) begin
    if (bus_sel && !bus_wr) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL scoreboard: read with no expected item, got %02h", bus_rdata);
      end else begin
        logic [NP-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          fails++;
          $display("FAIL %s: addr %0d read %02h expected %02h", t, bus_addr, bus_rdata, e);
        end
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [2:0] a, logic [NP-1:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(logic [2:0] a, logic [NP-1:0] e, string t);
    exp_q.push_back(e); tag_q.push_back(t);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    @(posedge clk); #1;
    bus_sel = 0;
  endtask

  task automatic chk(logic [31:0] act, logic [31:0] e, string t);
    checks++;
    if (act !== e) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", t, act, e);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    finish_run();
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    // R1 reset state
    for (int a = 0; a < 8; a++) rd(3'(a), '0, "R1");
    chk(port_irq, 0, "R1 port_irq"); chk(pin_irq, 0, "R1 pin_irq");
    chk(adc_cnt, 0, "R1 adc_trig");

    // R2 register map
    wr(3'd0, 8'hA5); rd(3'd0, 8'hA5, "R2 mode");
    wr(3'd0, 8'h00); wr(3'd6, 8'hFF); tick(1);
    rd(3'd4, 8'h00, "R2 raw after clear");
    wr(3'd1, 8'h3C); rd(3'd1, 8'h3C, "R2 both");
    wr(3'd2, 8'h5A); rd(3'd2, 8'h5A, "R2 pol");
    wr(3'd7, 8'hC3); rd(3'd7, 8'hC3, "R2 adc");
    wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
    rd(3'd4, 8'h00, "R2 raw read-only"); rd(3'd5, 8'h00, "R2 masked read-only");
    rd(3'd6, 8'h00, "R2 clear reads 0");
    wr(3'd1, 8'h00); wr(3'd2, 8'h00); wr(3'd7, 8'h00);

    // R3 rising edge on pin 1, masked and ADC-enabled
    wr(3'd2, 8'h02); wr(3'd3, 8'h02); wr(3'd7, 8'h02);
    c0 = adc_cnt;
    pins = 8'h02; tick(4);
    rd(3'd4, 8'h02, "R3 rising");
    rd(3'd5, 8'h02, "R7 masked");
    chk(port_irq, 1, "R8 port_irq");
    chk(pin_irq, 8'h03, "R9 pin lines");
    chk(adc_cnt - c0, 1, "R10 one pulse");
    pins = 8'h00; tick(4);
    rd(3'd4, 8'h02, "R5 sticky after falling");
    wr(3'd6, 8'h00); rd(3'd4, 8'h02, "R5 zero write ignored");
    wr(3'd6, 8'h02); rd(3'd4, 8'h00, "R5 write-one clear");
    chk(port_irq, 0, "R8 port_irq low");

    // R3 falling edge on pin 2, unmasked: no ADC pulse
    wr(3'd3, 8'h00); wr(3'd7, 8'h04);
    c0 = adc_cnt;
    pins = 8'h04; tick(4);
    rd(3'd4, 8'h00, "R3 wrong direction");
    pins = 8'h00; tick(4);
    rd(3'd4, 8'h04, "R3 falling");
    rd(3'd5, 8'h00, "R7 masked off");
    chk(port_irq, 0, "R8 masked off");
    chk(adc_cnt - c0, 0, "R10 masked pin no pulse");
    wr(3'd6, 8'h04); wr(3'd7, 8'h00);

    // R4 both edges on pin 3, polarity bit left 0
    wr(3'd1, 8'h08);
    pins = 8'h08; tick(4);
    rd(3'd4, 8'h08, "R4 rise");
    wr(3'd6, 8'h08);
    pins = 8'h00; tick(4);
    rd(3'd4, 8'h08, "R4 fall");
    wr(3'd3, 8'h08);
    chk(pin_irq, 8'h09, "R9 pin3 line");
    wr(3'd3, 8'h00); wr(3'd6, 8'h08);

    // R6 level-high on pin 4
    wr(3'd2, 8'h12); wr(3'd0, 8'h10);
    pins = 8'h10; tick(4);
    rd(3'd4, 8'h10, "R6 level high");
    wr(3'd6, 8'h10); tick(1);
    rd(3'd4, 8'h10, "R6 clear ignored");
    pins = 8'h00; tick(4);
    rd(3'd4, 8'h00, "R6 level released");

    // R6 level-low on pin 5
    wr(3'd0, 8'h30); tick(2);
    rd(3'd4, 8'h20, "R6 level low");
    pins = 8'h20; tick(4);
    rd(3'd4, 8'h00, "R6 low released");

    // R11 edge and clear in the same cycle on pin 6
    wr(3'd0, 8'h00); wr(3'd1, 8'h48);
    pins = 8'h60; tick(4);
    rd(3'd4, 8'h40, "R4 pin6 rise");
    pins = 8'h20; tick(2);
    wr(3'd6, 8'h40); tick(1);
    rd(3'd4, 8'h40, "R11 edge beats clear");
    wr(3'd6, 8'h40); tick(1);
    rd(3'd4, 8'h00, "R5 later clear");

    tick(2);
    finish_run();
  end
endmodule